// File: doc/BRIEF.md
# Dual Digital Potentiometer Command Engine

This block is the command and register controller for a two-channel digitally controlled resistor with 64 taps per channel. A bus front end passes it decoded events: a start (already matched to this device's address), a stop, each received byte, and during stepping mode a one-cycle pulse per serial clock pulse together with the sampled data line level. The engine holds one wiper counter per channel, which sets the tap position, and four stored setting registers per channel. The stored registers model nonvolatile cells: a write into them sets a busy timer.

The first byte after a start is an instruction byte. Its high nibble is the opcode. Bit 3 must be zero, bit 2 picks the channel and bits 1:0 pick one of the four setting registers. Some instructions finish at the instruction byte and move values between a wiper and a setting register, on one channel or on both. Others take one more byte, to write a wiper or a register from the host, or return a wiper or register value to the host. A stepping instruction moves the selected wiper one tap per clock pulse until the next stop. The engine answers every byte it consumes with an acknowledge or not-acknowledge. For reads it returns the value byte.

Top module: `dpot_cmd_engine`

## Requirements
- R1: After reset both wipers read 0, every setting register reads 0, `nv_busy` is low, and no acknowledge or read strobe is raised.
- R2: Opcodes are 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 register to wiper, 1110 wiper to register, 0001 global register to wiper, 1000 global wiper to register and 0010 step. Any other opcode, or an instruction byte with bit 3 set, is answered with `ack_ok`=0 one cycle after the byte and changes nothing.
- R3: A write-wiper instruction followed by a data byte sets the wiper of the channel selected by instruction bit 2 to data bits 5:0, one cycle after the data byte. Data bits 7:6 are ignored, and both bytes are acknowledged.
- R4: A read-wiper or read-register instruction is acknowledged, and in the same cycle `rd_valid` pulses with `rd_byte` = {2'b00, value}.
- R5: A write-register instruction plus data byte stores data bits 5:0 in the register selected by instruction bits 1:0. `nv_busy` is then high for exactly NV_WRITE_CYCLES cycles, starting the cycle after the data byte.
- R6: Register-to-wiper (1101) loads the selected channel's wiper from its selected register. The other channel's wiper is left unchanged.
- R7: Wiper-to-register (1110) stores the selected channel's wiper value into its selected register, and starts the busy period of R5.
- R8: The global forms (0001, 1000) perform the transfer of R6 or R7 on both channels at once, each using the same register index taken from bits 1:0.
- R9: While `nv_busy` is high, every instruction byte is answered with `ack_ok`=0, and no wiper or register changes.
- R10: After an accepted step instruction, each step pulse with `step_level`=1 raises the selected wiper by one and with `step_level`=0 lowers it by one. The wiper saturates at 63 and 0, and the other channel is unchanged.
- R11: Stepping mode ends at a stop. Step pulses outside stepping mode have no effect.
- R12: A stop or a new start before a command's last byte aborts that command with no register change. After a command completes, further bytes are answered with `ack_ok`=0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse: start condition addressed to this device |
| bus_stop | input | 1 | One-cycle pulse: stop condition |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| step_pulse | input | 1 | One-cycle pulse per serial clock pulse in stepping mode |
| step_level | input | 1 | Data line level sampled with `step_pulse` |
| ack_valid | output | 1 | Pulse one cycle after a consumed byte |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not acknowledge (valid with `ack_valid`) |
| rd_valid | output | 1 | Pulse: `rd_byte` holds read data |
| rd_byte | output | 8 | Read data, upper two bits zero |
| wiper0 | output | 6 | Channel 0 wiper position |
| wiper1 | output | 6 | Channel 1 wiper position |
| nv_busy | output | 1 | Stored-register write in progress |

## Verification
The assertions assume that the front end never raises `bus_start` and `bus_stop` in the same cycle. They also assume every input event is a single-cycle pulse, and that no store request reaches the register bank while it is busy, which the engine's own not-acknowledge rule guarantees. The bench drives every event for exactly one cycle on the falling clock edge and never overlaps a start with a stop. It also waits out or deliberately probes each busy window, so the stimulus stays inside those assumptions.

// File: rtl/dpot_pkg.sv
// Shared constants and types for the potentiometer command engine.
// Assumes two channels and four setting registers per channel, fixed by
// the instruction byte layout (one channel bit, two index bits).
package dpot_pkg;
    localparam int NCH    = 2;
    localparam int NREG   = 4;
    localparam int IDX_W  = $clog2(NREG);
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_BAD, OP_RD_W, OP_WR_W, OP_RD_D, OP_WR_D,
        OP_R2W, OP_W2R, OP_GR2W, OP_GW2R, OP_STEP
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_INSTR, S_DATA, S_STEP, S_DONE
    } eng_state_e;
endpackage

// File: rtl/dpot_op_decode.sv
// Instruction byte classifier: maps the opcode nibble to an operation kind.
// Assumes bit 3 of the instruction must be zero; otherwise the byte is invalid.
module dpot_op_decode
    import dpot_pkg::*;
(
    input  logic [BYTE_W-1:0] instr,
    output op_kind_e          kind
);
    // Decode the high nibble; reject reserved bit 3.
    always_comb begin
        kind = OP_BAD;
        if (!instr[3]) begin
            unique case (instr[7:4])
                4'b1001: kind = OP_RD_W;
                4'b1010: kind = OP_WR_W;
                4'b1011: kind = OP_RD_D;
                4'b1100: kind = OP_WR_D;
                4'b1101: kind = OP_R2W;
                4'b1110: kind = OP_W2R;
                4'b0001: kind = OP_GR2W;
                4'b1000: kind = OP_GW2R;
                4'b0010: kind = OP_STEP;
                default: kind = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/dpot_wiper.sv
// One wiper counter: parallel load or saturating single-tap step.
// Assumes load and step are never requested together; load wins if they are.
module dpot_wiper #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    input  logic         step_up,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] value_q;

    // Hold the tap position; load or step it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_en) begin
            value_q <= load_val;
        end else if (step_en) begin
            if (step_up && value_q != TOP)
                value_q <= value_q + 1'b1;
            else if (!step_up && value_q != '0)
                value_q <= value_q - 1'b1;
        end
    end

    assign value = value_q;

    AST_STEP_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !load_en && value_q == TOP) |=> value_q == TOP); // R10
    AST_STEP_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !load_en && value_q == '0) |=> value_q == '0); // R10
    AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !load_en && value_q != TOP) |=> value_q == $past(value_q) + 1'b1); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(value_q)); // R11
endmodule

// File: rtl/dpot_nv_bank.sv
// Setting register bank for all channels with a shared write-busy timer.
// Assumes every channel written in one cycle uses the same register index,
// and that no write is requested while busy (the engine refuses those).
module dpot_nv_bank
    import dpot_pkg::*;
#(
    parameter int W                = 6,
    parameter int NV_WRITE_CYCLES  = 20
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCH-1:0]                    wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [NCH-1:0][W-1:0]             wr_val,
    output logic [NCH-1:0][NREG-1:0][W-1:0]   regs,
    output logic                              busy
);
    localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1);

    logic [NCH-1:0][NREG-1:0][W-1:0] regs_q;
    logic [CNT_W-1:0]                cnt_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Store the value for this channel when requested.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[c] <= '0;
            else if (wr_en[c])
                regs_q[c][wr_idx] <= wr_val[c];
        end
    end

    // Count down the nonvolatile write time after each store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (|wr_en)
            cnt_q <= CNT_W'(NV_WRITE_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign regs = regs_q;
    assign busy = (cnt_q != '0);

    AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |=> busy); // R5
    AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(|wr_en)); // R9
endmodule

// File: rtl/dpot_cmd_engine.sv
// Command engine for a two-channel, 64-tap digital potentiometer.
// Consumes decoded bus events, runs the instruction set and the stepping
// mode, and drives both wipers. Assumes bus_start and bus_stop never
// coincide and all event inputs are single-cycle pulses.
module dpot_cmd_engine
    import dpot_pkg::*;
#(
    parameter int W               = 6,
    parameter int NV_WRITE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              step_pulse,
    input  logic              step_level,
    output logic              ack_valid,
    output logic              ack_ok,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [W-1:0]      wiper0,
    output logic [W-1:0]      wiper1,
    output logic              nv_busy
);
    eng_state_e                      state_q;
    op_kind_e                        op_q;
    op_kind_e                        op_now;
    logic                            ch_q;
    logic [IDX_W-1:0]                idx_q;
    logic                            sel_ch;
    logic [IDX_W-1:0]                sel_idx;
    logic                            no_event;
    logic                            instr_fire;
    logic                            accept;
    logic                            data_fire;
    logic                            step_fire;
    logic [NCH-1:0]                  w_load;
    logic [NCH-1:0][W-1:0]           w_load_val;
    logic [NCH-1:0]                  w_step;
    logic [NCH-1:0][W-1:0]           w_val;
    logic [NCH-1:0]                  nv_wr;
    logic [IDX_W-1:0]                nv_idx;
    logic [NCH-1:0][W-1:0]           nv_val;
    logic [NCH-1:0][NREG-1:0][W-1:0] nv_regs;
    logic                            busy;
    logic [W-1:0]                    rd_val;

    dpot_op_decode u_dec (
        .instr (rx_byte),
        .kind  (op_now)
    );

    assign sel_ch     = rx_byte[2];
    assign sel_idx    = rx_byte[IDX_W-1:0];
    assign no_event   = !bus_start && !bus_stop;
    assign instr_fire = (state_q == S_INSTR) && rx_valid && no_event;
    assign accept     = instr_fire && (op_now != OP_BAD) && !busy;
    assign data_fire  = (state_q == S_DATA) && rx_valid && no_event;
    assign step_fire  = (state_q == S_STEP) && step_pulse && no_event;

    // Build load, step and store requests for wipers and registers.
    always_comb begin
        w_load     = '0;
        w_load_val = '0;
        w_step     = '0;
        nv_wr      = '0;
        nv_val     = '0;
        nv_idx     = accept ? sel_idx : idx_q;
        if (accept) begin
            for (int c = 0; c < NCH; c++) begin
                unique case (op_now)
                    OP_R2W: if (sel_ch == c[0]) begin
                        w_load[c]     = 1'b1;
                        w_load_val[c] = nv_regs[c][sel_idx];
                    end
                    OP_GR2W: begin
                        w_load[c]     = 1'b1;
                        w_load_val[c] = nv_regs[c][sel_idx];
                    end
                    OP_W2R: if (sel_ch == c[0]) begin
                        nv_wr[c]  = 1'b1;
                        nv_val[c] = w_val[c];
                    end
                    OP_GW2R: begin
                        nv_wr[c]  = 1'b1;
                        nv_val[c] = w_val[c];
                    end
                    default: ;
                endcase
            end
        end
        if (data_fire) begin
            if (op_q == OP_WR_W) begin
                w_load[ch_q]     = 1'b1;
                w_load_val[ch_q] = rx_byte[W-1:0];
            end else begin
                nv_wr[ch_q]  = 1'b1;
                nv_val[ch_q] = rx_byte[W-1:0];
            end
        end
        if (step_fire)
            w_step[ch_q] = 1'b1;
    end

    // Value returned by a read instruction.
    always_comb begin
        if (op_now == OP_RD_W)
            rd_val = w_val[sel_ch];
        else
            rd_val = nv_regs[sel_ch][sel_idx];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_wiper
        dpot_wiper #(.W(W)) u_wiper (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (w_load[c]),
            .load_val (w_load_val[c]),
            .step_en  (w_step[c]),
            .step_up  (step_level),
            .value    (w_val[c])
        );
    end

    dpot_nv_bank #(.W(W), .NV_WRITE_CYCLES(NV_WRITE_CYCLES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (nv_wr),
        .wr_idx (nv_idx),
        .wr_val (nv_val),
        .regs   (nv_regs),
        .busy   (busy)
    );

    // Command sequencer: tracks the byte position and answers each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            op_q      <= OP_BAD;
            ch_q      <= 1'b0;
            idx_q     <= '0;
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            rd_valid  <= 1'b0;
            rd_byte   <= '0;
        end else begin
            ack_valid <= 1'b0;
            rd_valid  <= 1'b0;
            if (bus_start) begin
                state_q <= S_INSTR;
            end else if (bus_stop) begin
                state_q <= S_IDLE;
            end else if (rx_valid && state_q != S_IDLE) begin
                ack_valid <= 1'b1;
                ack_ok    <= 1'b0;
                state_q   <= S_DONE;
                if (state_q == S_INSTR && accept) begin
                    ack_ok <= 1'b1;
                    op_q   <= op_now;
                    ch_q   <= sel_ch;
                    idx_q  <= sel_idx;
                    if (op_now == OP_WR_W || op_now == OP_WR_D)
                        state_q <= S_DATA;
                    else if (op_now == OP_STEP)
                        state_q <= S_STEP;
                    if (op_now == OP_RD_W || op_now == OP_RD_D) begin
                        rd_valid <= 1'b1;
                        rd_byte  <= BYTE_W'(rd_val);
                    end
                end else if (state_q == S_DATA) begin
                    ack_ok <= 1'b1;
                end else if (state_q == S_STEP) begin
                    state_q <= S_STEP;
                end
            end
        end
    end

    assign wiper0  = w_val[0];
    assign wiper1  = w_val[1];
    assign nv_busy = busy;

    AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_fire && busy) |=> (ack_valid && !ack_ok)); // R9
    AST_READ_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_byte >> W) == '0 && ack_valid && ack_ok)); // R4
    AST_IDLE_WIPERS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> $stable(w_val)); // R11
    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !bus_start) |=> !ack_valid); // R12
    AST_EVENTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_start && bus_stop)); // R12
endmodule

// File: tb/dpot_cmd_engine_bench.sv
// Directed bench for the potentiometer command engine.
module dpot_cmd_engine_bench;
    localparam int W    = 6;
    localparam int NVW  = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_start = 1'b0;
    logic         bus_stop = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_byte = '0;
    logic         step_pulse = 1'b0;
    logic         step_level = 1'b0;
    logic         ack_valid, ack_ok, rd_valid, nv_busy;
    logic [7:0]   rd_byte;
    logic [W-1:0] wiper0, wiper1;

    int checks = 0;
    int errors = 0;
    logic last_ackv, last_ack, last_rdv;
    logic [7:0] last_rd;

    always #2 clk = ~clk;

    dpot_cmd_engine #(.W(W), .NV_WRITE_CYCLES(NVW)) u_dpot_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .step_pulse(step_pulse),
        .step_level(step_level), .ack_valid(ack_valid), .ack_ok(ack_ok),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .wiper0(wiper0),
        .wiper1(wiper1), .nv_busy(nv_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        last_ackv = ack_valid; last_ack = ack_ok;
        last_rdv = rd_valid;   last_rd = rd_byte;
    endtask

    task automatic step(input logic up);
        @(negedge clk); step_pulse = 1'b1; step_level = up;
        @(negedge clk); step_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && nv_busy; i++) @(negedge clk);
    endtask

    task automatic read_val(input logic [7:0] instr, input int exp, input string req);
        do_start();
        send(instr);
        check(last_ackv && last_ack && last_rdv, req, {last_ackv, last_ack, last_rdv}, 7);
        check(last_rd == 8'(exp), req, last_rd, exp);
        do_stop();
    endtask

    task automatic write2(input logic [7:0] instr, input logic [7:0] data);
        do_start(); send(instr); send(data); do_stop();
    endtask

    task automatic t_reset();
        check(wiper0 == 0 && wiper1 == 0, "R1", {wiper1, wiper0}, 0);
        check(!nv_busy && !ack_valid && !rd_valid, "R1", {nv_busy, ack_valid, rd_valid}, 0);
        read_val(8'hB7, 0, "R1");
    endtask

    task automatic t_write_wiper();
        do_start();
        send(8'hA0);
        check(last_ackv && last_ack, "R3", last_ack, 1);
        send(8'hE5);
        check(last_ackv && last_ack, "R3", last_ack, 1);
        check(wiper0 == 37 && wiper1 == 0, "R3", {wiper1, wiper0}, 37);
        send(8'h11);
        check(last_ackv && !last_ack, "R12", last_ack, 0);
        do_stop();
        write2(8'hA4, 8'h3F);
        check(wiper1 == 63, "R3", wiper1, 63);
        read_val(8'h90, 37, "R4");
        read_val(8'h94, 63, "R4");
    endtask

    task automatic t_write_reg();
        int cnt = 0;
        do_start(); send(8'hC6); send(8'h4A);
        check(last_ack, "R5", last_ack, 1);
        while (nv_busy && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == NVW, "R5", cnt, NVW);
        do_stop();
        read_val(8'hB6, 10, "R5");
        // busy refusal
        write2(8'hC1, 8'h07);
        do_start(); send(8'hA0);
        check(last_ackv && !last_ack && nv_busy, "R9", last_ack, 0);
        send(8'h05);
        check(!last_ack && wiper0 == 37, "R9", wiper0, 37);
        do_stop();
        wait_idle();
        read_val(8'hB1, 7, "R9");
    endtask

    task automatic t_transfers();
        do_start(); send(8'hD6);
        check(last_ack && wiper1 == 10 && wiper0 == 37, "R6", wiper1, 10);
        do_stop();
        do_start(); send(8'hE1);
        check(last_ack, "R7", last_ack, 1);
        @(negedge clk);
        check(nv_busy, "R7", nv_busy, 1);
        do_stop(); wait_idle();
        read_val(8'hB1, 37, "R7");
    endtask

    task automatic t_global();
        write2(8'hC3, 8'h05); wait_idle();
        write2(8'hC7, 8'h32); wait_idle();
        do_start(); send(8'h13);
        check(last_ack && wiper0 == 5 && wiper1 == 50, "R8", {wiper1, wiper0}, {6'd50, 6'd5});
        do_stop();
        do_start(); send(8'h80); do_stop(); wait_idle();
        read_val(8'hB0, 5, "R8");
        read_val(8'hB4, 50, "R8");
    endtask

    task automatic t_bad_op();
        do_start(); send(8'h30);
        check(last_ackv && !last_ack, "R2", last_ack, 0);
        do_stop();
        do_start(); send(8'hA8);
        check(last_ackv && !last_ack, "R2", last_ack, 0);
        send(8'h01);
        check(wiper0 == 5 && wiper1 == 50 && !last_ack, "R2", wiper0, 5);
        do_stop();
    endtask

    task automatic t_step();
        do_start(); send(8'h20);
        check(last_ack, "R10", last_ack, 1);
        for (int i = 0; i < 3; i++) step(1'b1);
        check(wiper0 == 8 && wiper1 == 50, "R10", wiper0, 8);
        for (int i = 0; i < 10; i++) step(1'b0);
        check(wiper0 == 0, "R10", wiper0, 0);
        do_stop();
        do_start(); send(8'h24);
        for (int i = 0; i < 20; i++) step(1'b1);
        check(wiper1 == 63 && wiper0 == 0, "R10", wiper1, 63);
        do_stop();
        step(1'b0); step(1'b0);
        check(wiper1 == 63, "R11", wiper1, 63);
    endtask

    task automatic t_abort();
        do_start(); send(8'hA4); do_stop();
        @(negedge clk);
        check(wiper1 == 63, "R12", wiper1, 63);
        do_start(); send(8'hC4); do_start(); send(8'h94);
        check(last_rdv && last_rd == 63 && !nv_busy, "R12", last_rd, 63);
        do_stop();
        read_val(8'hB4, 50, "R12");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_wiper();
        t_write_reg();
        t_transfers();
        t_global();
        t_bad_op();
        t_step();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule